// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block sits between a processor's instruction fetch port and a memory port that supplies line refills. It stores 1 KB of instructions as two ways of 32 sets, with four 32-bit words per line. A fetch that hits returns its word on the next cycle. A fetch that misses reads the whole line from memory as four word reads. The line is placed in a way picked by a per-set least-recently-used bit, and the requested word is returned once the last word of the line has arrived.

Software can make code resident. While `pin_mode` is high, every line that gets filled is marked pinned. A pinned line is never picked as a victim. If both ways of a set are pinned, a miss in that set is served straight from memory and nothing is installed. A one-cycle `purge` pulse drops every unpinned line and leaves pinned lines valid.

Top module: `pinned_icache`

## Requirements
- R1: After reset every line is invalid and unpinned. `fetch_ready` is 1, `fetch_valid` is 0 and `mem_req` is 0, and the first fetch to any address misses.
- R2: A fetch is accepted on a rising edge where `fetch_req` and `fetch_ready` are both 1. If it hits, `fetch_valid` is 1 in the following cycle and carries the stored word, and the memory port makes no request.
- R3: A miss makes exactly four memory reads. They start at the line base and go up by 4 bytes per read, with one outstanding read that finishes on a cycle with `mem_valid` high. `fetch_valid` comes in the cycle after the fourth response and carries the word the fetch addressed.
- R4: Bits [3:2] of the byte address select the word in the line, bits [8:4] select the set, and bits [31:9] form the tag. Bits [1:0] are ignored.
- R5: On an allocating miss the victim is chosen in this order: an invalid way 0, then an invalid way 1, then the least-recently-used way of the set. A hit or a fill makes its way the most recently used.
- R6: A line filled while `pin_mode` is 1 is pinned. When exactly one way of a set is pinned, a miss in that set replaces the other way, whatever the LRU bit says.
- R7: When both ways of a set are pinned, a miss still returns the correct word after four reads, but installs nothing. The two pinned lines keep hitting, and the missed address misses again.
- R8: `purge` acts on a cycle when the cache is idle. In that cycle `fetch_ready` is 0, and afterwards unpinned lines are invalid while pinned lines still hit.
- R9: `fetch_ready` stays 0 for the whole refill, so only one fetch is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Byte address of the fetch |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| fetch_valid | output | 1 | One-cycle pulse: `fetch_data` is valid |
| fetch_data | output | 32 | Returned instruction word |
| pin_mode | input | 1 | Mark lines filled from now on as pinned |
| purge | input | 1 | Invalidate all unpinned lines |
| mem_req | output | 1 | Refill read request, held until answered |
| mem_addr | output | 32 | Word address of the refill read |
| mem_valid | input | 1 | Refill read response strobe |
| mem_data | input | 32 | Refill read data |

## Verification
The hardest situation to reach is a set where the LRU bit names a pinned way, or where both ways are pinned. Plain fetches cannot produce it. The bench builds it on purpose. It fills way 0 of a chosen set with `pin_mode` high, then fills way 1 unpinned, so the LRU bit ends up pointing at the pinned way. A third tag for that set must then displace way 1. A second set has both ways pinned, and repeated fetches of a third tag show bypass with no install. A purge then tells pinned lines apart from unpinned ones by the number of memory reads that follow.

// File: rtl/pinned_icache_pkg.sv
package pinned_icache_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_FILL = 1'b1
    } phase_e;
endpackage

// File: rtl/pic_tag_store.sv
module pic_tag_store #(
    parameter int SETS  = 32,
    parameter int TAG_W = 23,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             victim_way,
    output logic             no_room,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way,
    input  logic             inst_en,
    input  logic [IDX_W-1:0] inst_idx,
    input  logic             inst_way,
    input  logic [TAG_W-1:0] inst_tag,
    input  logic             inst_pin,
    input  logic             purge_en
);
    typedef struct packed {
        logic [1:0][SETS-1:0]            vld;
        logic [1:0][SETS-1:0]            pin;
        logic [SETS-1:0]                 lru;   // way to evict next
        logic [1:0][SETS-1:0][TAG_W-1:0] tag;
    } tags_t;

    tags_t ts_d, ts_q;
    logic  m0, m1, v0, v1, p0, p1;

    always_comb begin
        m0 = ts_q.vld[0][lk_idx] && (ts_q.tag[0][lk_idx] == lk_tag);
        m1 = ts_q.vld[1][lk_idx] && (ts_q.tag[1][lk_idx] == lk_tag);
        hit     = m0 | m1;
        hit_way = m1;
        v0 = ts_q.vld[0][lk_idx];
        v1 = ts_q.vld[1][lk_idx];
        p0 = ts_q.pin[0][lk_idx];
        p1 = ts_q.pin[1][lk_idx];
        no_room = p0 & p1;
        if (!v0)      victim_way = 1'b0;
        else if (!v1) victim_way = 1'b1;
        else if (p0)  victim_way = 1'b1;
        else if (p1)  victim_way = 1'b0;
        else          victim_way = ts_q.lru[lk_idx];
    end

    always_comb begin
        ts_d = ts_q;
        if (purge_en) begin
            for (int w = 0; w < 2; w++) begin
                ts_d.vld[w] = ts_q.vld[w] & ts_q.pin[w];
            end
        end
        if (touch_en) begin
            ts_d.lru[touch_idx] = ~touch_way;
        end
        if (inst_en) begin
            ts_d.vld[inst_way][inst_idx] = 1'b1;
            ts_d.pin[inst_way][inst_idx] = inst_pin;
            ts_d.tag[inst_way][inst_idx] = inst_tag;
            ts_d.lru[inst_idx]           = ~inst_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    // R6
    pin_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ts_q.pin[0] & ~ts_q.vld[0]) == '0) && ((ts_q.pin[1] & ~ts_q.vld[1]) == '0));

    // R6
    no_pinned_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |-> !ts_q.pin[inst_way][inst_idx]);

    // R8
    purge_keeps_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purge_en |=> (ts_q.pin[0] == $past(ts_q.pin[0])) && (ts_q.pin[1] == $past(ts_q.pin[1])));
endmodule

// File: rtl/pic_data_store.sv
module pic_data_store #(
    parameter int SETS   = 32,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    logic [1:0][SETS-1:0][WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    assign rd_data = mem_q[rd_way][rd_idx][rd_off];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_way][wr_idx][wr_off] = wr_data;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pinned_icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int LINE_W = ADDR_W - OFF_W - 2,
    localparam int TAG_W  = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    input  logic              pin_mode,
    input  logic              purge,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic              hit,
    input  logic              hit_way,
    input  logic              victim_way,
    input  logic              no_room,
    output logic              touch_en,
    output logic [IDX_W-1:0]  touch_idx,
    output logic              touch_way,
    output logic              inst_en,
    output logic [IDX_W-1:0]  inst_idx,
    output logic              inst_way,
    output logic [TAG_W-1:0]  inst_tag,
    output logic              inst_pin,
    output logic              purge_en,
    output logic              rd_way,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [OFF_W-1:0]  rd_off,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic              wr_way,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [OFF_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

    typedef struct packed {
        phase_e              ph;
        logic [LINE_W-1:0]   line;
        logic [OFF_W-1:0]    want;
        logic [OFF_W-1:0]    cnt;
        logic                way;
        logic                alloc;
        logic                rsp_vld;
        logic [DATA_W-1:0]   rsp_data;
    } ctl_t;

    ctl_t cs_d, cs_q;
    logic accept;
    logic unused_byte;

    assign unused_byte = ^fetch_addr[1:0];

    always_comb begin
        cs_d         = cs_q;
        cs_d.rsp_vld = 1'b0;

        fetch_ready = (cs_q.ph == PH_IDLE) && !purge;
        purge_en    = (cs_q.ph == PH_IDLE) && purge;
        accept      = fetch_ready && fetch_req;

        lk_idx = fetch_addr[IDX_W+OFF_W+1:OFF_W+2];
        lk_tag = fetch_addr[ADDR_W-1:IDX_W+OFF_W+2];
        rd_way = hit_way;
        rd_idx = lk_idx;
        rd_off = fetch_addr[OFF_W+1:2];

        touch_en  = 1'b0;
        touch_idx = lk_idx;
        touch_way = hit_way;

        inst_en  = 1'b0;
        inst_idx = cs_q.line[IDX_W-1:0];
        inst_way = cs_q.way;
        inst_tag = cs_q.line[LINE_W-1:IDX_W];
        inst_pin = pin_mode;

        mem_req  = (cs_q.ph == PH_FILL);
        mem_addr = {cs_q.line, cs_q.cnt, 2'b00};

        wr_en   = 1'b0;
        wr_way  = cs_q.way;
        wr_idx  = cs_q.line[IDX_W-1:0];
        wr_off  = cs_q.cnt;
        wr_data = mem_data;

        case (cs_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    if (hit) begin
                        cs_d.rsp_vld  = 1'b1;
                        cs_d.rsp_data = rd_data;
                        touch_en      = 1'b1;
                    end else begin
                        cs_d.ph    = PH_FILL;
                        cs_d.line  = fetch_addr[ADDR_W-1:OFF_W+2];
                        cs_d.want  = fetch_addr[OFF_W+1:2];
                        cs_d.cnt   = '0;
                        cs_d.way   = victim_way;
                        cs_d.alloc = !no_room;
                    end
                end
            end
            PH_FILL: begin
                if (mem_valid) begin
                    wr_en = cs_q.alloc;
                    if (cs_q.cnt == cs_q.want) cs_d.rsp_data = mem_data;
                    cs_d.cnt = cs_q.cnt + 1'b1;
                    if (cs_q.cnt == LAST) begin
                        cs_d.ph      = PH_IDLE;
                        cs_d.rsp_vld = 1'b1;
                        inst_en      = cs_q.alloc;
                    end
                end
            end
            default: cs_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign fetch_valid = cs_q.rsp_vld;
    assign fetch_data  = cs_q.rsp_data;

    // R2
    hit_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (fetch_valid && !mem_req));

    // R3
    refill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && (cs_q.cnt != LAST)) |=>
            (mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(4))));

    // R3
    refill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && (cs_q.cnt == LAST)) |=> (fetch_valid && !mem_req));

    // R3
    miss_starts_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (mem_req && (mem_addr[OFF_W+1:0] == '0)));
endmodule

// File: rtl/pinned_icache.sv
module pinned_icache #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    input  logic              pin_mode,
    input  logic              purge,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int TAG_W  = ADDR_W - OFF_W - 2 - IDX_W;

    logic [IDX_W-1:0]  lk_idx, touch_idx, inst_idx, rd_idx, wr_idx;
    logic [TAG_W-1:0]  lk_tag, inst_tag;
    logic              hit, hit_way, victim_way, no_room;
    logic              touch_en, touch_way, inst_en, inst_way, inst_pin, purge_en;
    logic              rd_way, wr_en, wr_way;
    logic [OFF_W-1:0]  rd_off, wr_off;
    logic [DATA_W-1:0] rd_data, wr_data;

    pic_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .pin_mode(pin_mode), .purge(purge),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .hit(hit), .hit_way(hit_way),
        .victim_way(victim_way), .no_room(no_room),
        .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way),
        .inst_en(inst_en), .inst_idx(inst_idx), .inst_way(inst_way),
        .inst_tag(inst_tag), .inst_pin(inst_pin), .purge_en(purge_en),
        .rd_way(rd_way), .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data)
    );

    pic_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way), .no_room(no_room),
        .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way),
        .inst_en(inst_en), .inst_idx(inst_idx), .inst_way(inst_way),
        .inst_tag(inst_tag), .inst_pin(inst_pin), .purge_en(purge_en)
    );

    pic_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_way(rd_way), .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data)
    );

    // R9
    busy_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fetch_ready);

    // R8
    purge_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (purge && !mem_req) |-> !fetch_ready);
endmodule

// File: tb/pinned_icache_bench.sv
module pinned_icache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, fetch_valid;
    logic [31:0] fetch_data;
    logic        pin_mode = 1'b0;
    logic        purge = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = '0;

    int checks = 0;
    int fails  = 0;
    int mem_words = 0;
    logic [31:0] addr_log [4];
    bit done = 1'b0;

    always #5 clk = ~clk;

    pinned_icache u_pinned_icache (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .pin_mode(pin_mode), .purge(purge),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    // memory model: answers one word per cycle, sampled at negedge
    always @(negedge clk) begin
        if (mem_req) begin
            mem_valid = 1'b1;
            mem_data  = pat(mem_addr);
            if (mem_words < 4) addr_log[mem_words] = mem_addr;
            mem_words++;
        end else begin
            mem_valid = 1'b0;
            mem_data  = '0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit miss, input string req);
        int  n;
        bit  busy_seen;
        @(negedge clk);
        mem_words  = 0;
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
        n = 0;
        busy_seen = 1'b0;
        while (!fetch_valid && n < 20) begin
            if (n == 1 && !fetch_ready) busy_seen = 1'b1;
            @(negedge clk);
            n++;
        end
        chk(fetch_valid, req, "response seen", {31'd0, fetch_valid}, 32'd1);
        chk(fetch_data == pat(a & ~32'h3), req, "data", fetch_data, pat(a & ~32'h3));
        chk(mem_words == (miss ? 4 : 0), req, "memory reads", mem_words, miss ? 4 : 0);
        chk(n == (miss ? 4 : 0), req, "latency", n, miss ? 4 : 0);
        if (miss) begin
            bit order_ok = 1'b1;
            for (int k = 0; k < 4; k++) begin
                if (addr_log[k] != (a & ~32'hF) + 32'(4 * k)) order_ok = 1'b0;
            end
            chk(order_ok, "R3", "refill address order", addr_log[3], (a & ~32'hF) + 32'd12);
            chk(busy_seen, "R9", "ready low during refill", {31'd0, busy_seen}, 32'd1);
        end
    endtask

    // {address, expect miss}
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {32'h0000_0000, 1'b1},  // R1 cold miss, R5 invalid way 0
        {32'h0000_0004, 1'b0},
        {32'h0000_000C, 1'b0},  // R4 word offset
        {32'h0000_000B, 1'b0},  // R4 low bits ignored
        {32'h0000_0400, 1'b1},  // R5 invalid way 1
        {32'h0000_0000, 1'b0},
        {32'h0000_0800, 1'b1},  // R5 LRU evicts tag 1
        {32'h0000_0008, 1'b0},
        {32'h0000_0404, 1'b1},
        {32'h0000_080C, 1'b1},
        {32'h0000_0404, 1'b0},
        {32'h0000_0000, 1'b1},
        {32'h0000_0010, 1'b1},  // R4 next set
        {32'h0000_001C, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset outputs
        chk(fetch_ready == 1'b1, "R1", "fetch_ready", {31'd0, fetch_ready}, 32'd1);
        chk(fetch_valid == 1'b0, "R1", "fetch_valid", {31'd0, fetch_valid}, 32'd0);
        chk(mem_req == 1'b0, "R1", "mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_ready == 1'b1, "R1", "ready after reset", {31'd0, fetch_ready}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            do_fetch(VEC[i][32:1], VEC[i][0], VEC[i][0] ? "R3/R5" : "R2");
        end

        // R6: one pinned way, LRU points at it
        pin_mode = 1'b1;
        do_fetch(32'h0000_0050, 1'b1, "R6");
        pin_mode = 1'b0;
        do_fetch(32'h0000_0450, 1'b1, "R6");
        do_fetch(32'h0000_0850, 1'b1, "R6");
        do_fetch(32'h0000_0054, 1'b0, "R6");
        do_fetch(32'h0000_0858, 1'b0, "R6");
        do_fetch(32'h0000_0450, 1'b1, "R6");

        // R7: both ways pinned
        pin_mode = 1'b1;
        do_fetch(32'h0000_0060, 1'b1, "R7");
        do_fetch(32'h0000_0460, 1'b1, "R7");
        pin_mode = 1'b0;
        do_fetch(32'h0000_0860, 1'b1, "R7");
        do_fetch(32'h0000_0864, 1'b1, "R7");
        do_fetch(32'h0000_0068, 1'b0, "R7");
        do_fetch(32'h0000_046C, 1'b0, "R7");

        // R8: purge
        @(negedge clk);
        purge = 1'b1;
        #1;
        chk(fetch_ready == 1'b0, "R8", "ready during purge", {31'd0, fetch_ready}, 32'd0);
        @(negedge clk);
        purge = 1'b0;
        do_fetch(32'h0000_0050, 1'b0, "R8");
        do_fetch(32'h0000_0064, 1'b0, "R8");
        do_fetch(32'h0000_0460, 1'b0, "R8");
        do_fetch(32'h0000_0450, 1'b1, "R8");
        do_fetch(32'h0000_0010, 1'b1, "R8");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule